// File: doc/BRIEF.md
# Block Pattern Sequencer with Alternation

This block is a serial bit source. Software fills an on-chip pattern memory through a word-wide write port. On a start event the block plays that memory as a bit stream, one bit per accepted transfer. It runs in one of two ways.

In sequence mode the memory holds up to four back-to-back blocks, each sized in whole granules. A single loop can repeat a contiguous range of those blocks either a set number of times or without end. In alternate mode the memory is treated as two equal halves that each hold one pattern. An auxiliary input decides, at each pattern end only, which half plays next.

The auxiliary input can also start a sequence. Outside alternate mode it can instead blank the data. The bit stream leaves on a valid/ready pair. The consumer may hold `out_ready` low for any number of cycles. While it does, the bit on `out_bit` and the play position stay frozen, and no bit is ever skipped or repeated. The write port is also valid/ready. It accepts a word only while no sequence is running.

Top module: `pseq_top`

## Requirements
- R1: After reset, out_valid, out_bit, busy and done are 0 and wr_ready is 1.
- R2: Bit i of memory word w is pattern bit w*WORD_W+i, and patterns play from bit 0 upward. wr_ready is 1 exactly when no sequence is running, and a write offered while wr_ready is 0 leaves the memory unchanged.
- R3: In sequence mode, blocks 0 to cfg_last_blk play in order. Block k is cfg_blk_len field k (bits k*LEN_W upward) times GRAN bits long, and each block starts where the previous one ended, with block 0 at bit 0.
- R4: With cfg_loop_en set, after the last bit of block cfg_loop_last the sequence goes back to block cfg_loop_first until the range has played cfg_loop_cnt times in total (a count of 0 acts as 1). Playback then carries on with the following blocks.
- R5: With cfg_loop_inf set as well, the loop range repeats until a stop command.
- R6: After the final bit of the last block has been transferred, done is 1, and out_valid and out_bit stay 0 until the next start.
- R7: A bit is consumed only in a cycle with out_valid and out_ready both high. While out_ready is low, out_bit and the play position hold.
- R8: A sequence starts on cmd_start, or on a rising edge of aux_in when cfg_start_aux is 1, but only while not running; a start while running is ignored. cmd_stop returns the block to idle with busy and done at 0. aux_in passes a two-flop synchronizer before any use.
- R9: In alternate mode, half h begins at bit h*MEM_BITS/2, each pattern is cfg_alt_len*GRAN bits, the first pattern after a start is half 0, and the active half can change only at a pattern end.
- R10: With cfg_aux_mode 1 and cfg_oneshot 0, each aux rising edge flips the target half, and the next pattern end switches to the target, which then stays.
- R11: With cfg_aux_mode 1 and cfg_oneshot 1, an aux rising edge makes half 1 play once at the next pattern end, after which half 0 resumes.
- R12: With cfg_aux_mode 2, at each pattern end the next half equals the synchronized aux level.
- R13: With cfg_aux_mode 3 and alternate mode off, out_bit is 0 while the synchronized aux level is high, and the position keeps advancing. In alternate mode, mode 3 has no effect and half 0 repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write accepted (idle or done) |
| wr_addr | input | WA_W | Memory word index |
| wr_data | input | WORD_W | Memory word, bit 0 plays first |
| cmd_start | input | 1 | Start command |
| cmd_stop | input | 1 | Stop command, back to idle |
| aux_in | input | 1 | Asynchronous auxiliary input |
| cfg_start_aux | input | 1 | Aux rising edge also starts |
| cfg_alt_en | input | 1 | Alternate two-half mode |
| cfg_aux_mode | input | 2 | 0 none, 1 pulse, 2 level, 3 blank |
| cfg_oneshot | input | 1 | Pulse mode plays other half once |
| cfg_last_blk | input | BLK_W | Index of final block |
| cfg_blk_len | input | NBLK*LEN_W | Block lengths in granules |
| cfg_loop_en | input | 1 | Loop enable |
| cfg_loop_first | input | BLK_W | First block of loop range |
| cfg_loop_last | input | BLK_W | Last block of loop range |
| cfg_loop_cnt | input | CNT_W | Loop plays in total |
| cfg_loop_inf | input | 1 | Loop without end |
| cfg_alt_len | input | LEN_W | Alternate pattern length in granules |
| out_valid | output | 1 | Bit available |
| out_ready | input | 1 | Consumer takes bit |
| out_bit | output | 1 | Serial data bit |
| busy | output | 1 | Sequence running |
| done | output | 1 | Finite sequence finished |
| cur_blk | output | BLK_W | Block now playing |
| cur_half | output | 1 | Half now playing |

## Verification
`out_bit` shows the bit at the current position in the same cycle, and the position moves on the clock edge of each transfer. So the scoreboard compares every transferred bit against the bench's own model in the cycle it is offered. A start command makes the first bit valid one edge later, and done rises on the edge that takes the last bit. An aux change needs two edges to reach the synchronized level, which controls blanking and level selection, and a third edge for a pulse to register. The bench therefore changes aux_in only while out_ready is held low, and waits four cycles before it lets transfers resume. This way every effect of aux is in place before the next compared bit.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  localparam logic [1:0] AUX_NONE  = 2'd0;
  localparam logic [1:0] AUX_PULSE = 2'd1;
  localparam logic [1:0] AUX_LEVEL = 2'd2;
  localparam logic [1:0] AUX_MUTE  = 2'd3;
endpackage

// File: rtl/seq_aux_sync.sv
module seq_aux_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic aux_in,
  output logic aux_lvl,
  output logic aux_rise
);
  logic meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= aux_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign aux_lvl  = lvl_q;
  assign aux_rise = lvl_q & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rise |=> !aux_rise); // R8
endmodule

// File: rtl/seq_bit_store.sv
module seq_bit_store #(
  parameter int WORD_W   = 32,
  parameter int MEM_BITS = 2048,
  localparam int DEPTH   = MEM_BITS / WORD_W,
  localparam int OFS_W   = $clog2(WORD_W),
  localparam int BA_W    = $clog2(MEM_BITS),
  localparam int WA_W    = BA_W - OFS_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BA_W-1:0]   rd_addr,
  output logic              rd_bit
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_bit = mem_q[rd_addr[BA_W-1:OFS_W]][rd_addr[OFS_W-1:0]];
endmodule

// File: rtl/seq_block_map.sv
module seq_block_map #(
  parameter int MEM_BITS = 2048,
  parameter int GRAN     = 512,
  parameter int NBLK     = 4,
  localparam int BA_W    = $clog2(MEM_BITS),
  localparam int LB_W    = BA_W + 1,
  localparam int LEN_W   = $clog2(MEM_BITS / GRAN + 1)
) (
  input  logic [NBLK*LEN_W-1:0] cfg_blk_len,
  output logic [NBLK*BA_W-1:0]  blk_base_flat,
  output logic [NBLK*LB_W-1:0]  blk_bits_flat
);
  logic [LB_W-1:0] bits_w [NBLK];
  logic [BA_W-1:0] base_w [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign bits_w[g] = LB_W'(cfg_blk_len[g*LEN_W +: LEN_W]) * LB_W'(GRAN);
    if (g == 0) begin : g_first
      assign base_w[g] = '0;
    end else begin : g_next
      assign base_w[g] = base_w[g-1] + BA_W'(bits_w[g-1]);
    end
    assign blk_base_flat[g*BA_W +: BA_W] = base_w[g];
    assign blk_bits_flat[g*LB_W +: LB_W] = bits_w[g];
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int MEM_BITS = 2048,
  parameter int GRAN     = 512,
  parameter int NBLK     = 4,
  parameter int CNT_W    = 16,
  localparam int BA_W    = $clog2(MEM_BITS),
  localparam int LB_W    = BA_W + 1,
  localparam int LEN_W   = $clog2(MEM_BITS / GRAN + 1),
  localparam int BLK_W   = $clog2(NBLK),
  localparam int HALF    = MEM_BITS / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_start,
  input  logic                  cmd_stop,
  input  logic                  aux_lvl,
  input  logic                  aux_rise,
  input  logic                  cfg_start_aux,
  input  logic                  cfg_alt_en,
  input  logic [1:0]            cfg_aux_mode,
  input  logic                  cfg_oneshot,
  input  logic [BLK_W-1:0]      cfg_last_blk,
  input  logic                  cfg_loop_en,
  input  logic [BLK_W-1:0]      cfg_loop_first,
  input  logic [BLK_W-1:0]      cfg_loop_last,
  input  logic [CNT_W-1:0]      cfg_loop_cnt,
  input  logic                  cfg_loop_inf,
  input  logic [LEN_W-1:0]      cfg_alt_len,
  input  logic [NBLK*BA_W-1:0]  blk_base_flat,
  input  logic [NBLK*LB_W-1:0]  blk_bits_flat,
  input  logic                  out_ready,
  output logic [BA_W-1:0]       rd_addr,
  output logic                  busy,
  output logic                  done,
  output logic [BLK_W-1:0]      cur_blk,
  output logic                  cur_half
);
  seq_state_t      st;
  logic [BA_W-1:0]  off;
  logic [BLK_W-1:0] blk;
  logic [CNT_W-1:0] iter;
  logic             half, tgt, req, alt_q;

  logic [BA_W-1:0] base_arr [NBLK];
  logic [LB_W-1:0] bits_arr [NBLK];
  for (genvar g = 0; g < NBLK; g++) begin : g_unpack
    assign base_arr[g] = blk_base_flat[g*BA_W +: BA_W];
    assign bits_arr[g] = blk_bits_flat[g*LB_W +: LB_W];
  end

  logic [LB_W-1:0]  cur_len;
  logic             at_end, fire, start_trig, loop_again, next_half;
  logic [CNT_W-1:0] cnt_eff;

  assign cur_len    = alt_q ? (LB_W'(cfg_alt_len) * LB_W'(GRAN)) : bits_arr[blk];
  assign at_end     = ({1'b0, off} + LB_W'(1)) >= cur_len;
  assign fire       = (st == ST_RUN) && out_ready;
  assign start_trig = cmd_start | (cfg_start_aux & aux_rise);
  assign cnt_eff    = (cfg_loop_cnt == '0) ? CNT_W'(1) : cfg_loop_cnt;
  assign loop_again = cfg_loop_en && (blk == cfg_loop_last) &&
                      (cfg_loop_inf || (({1'b0, iter} + (CNT_W+1)'(1)) < {1'b0, cnt_eff}));

  always_comb begin
    case (cfg_aux_mode)
      AUX_PULSE: next_half = cfg_oneshot ? (!half && (req || aux_rise)) : (tgt ^ aux_rise);
      AUX_LEVEL: next_half = aux_lvl;
      default:   next_half = 1'b0;
    endcase
  end

  always_comb begin
    if (alt_q) rd_addr = (half ? BA_W'(HALF) : '0) + off;
    else       rd_addr = base_arr[blk] + off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      off   <= '0;
      blk   <= '0;
      iter  <= '0;
      half  <= 1'b0;
      tgt   <= 1'b0;
      req   <= 1'b0;
      alt_q <= 1'b0;
    end else if (cmd_stop) begin
      st <= ST_IDLE;
    end else if (st != ST_RUN) begin
      if (start_trig) begin
        st    <= ST_RUN;
        off   <= '0;
        blk   <= '0;
        iter  <= '0;
        half  <= 1'b0;
        tgt   <= 1'b0;
        req   <= 1'b0;
        alt_q <= cfg_alt_en;
      end
    end else begin
      if (aux_rise) begin
        tgt <= ~tgt;
        req <= 1'b1;
      end
      if (fire) begin
        if (!at_end) begin
          off <= off + BA_W'(1);
        end else begin
          off <= '0;
          if (alt_q) begin
            half <= next_half;
            if (!half && next_half) req <= 1'b0;
          end else if (loop_again) begin
            blk  <= cfg_loop_first;
            iter <= iter + CNT_W'(1);
          end else if (blk == cfg_last_blk) begin
            st <= ST_DONE;
          end else begin
            blk <= blk + BLK_W'(1);
          end
        end
      end
    end
  end

  assign busy     = (st == ST_RUN);
  assign done     = (st == ST_DONE);
  assign cur_blk  = blk;
  assign cur_half = half;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !out_ready && !cmd_stop) |=> ($stable(off) && $stable(blk) && $stable(half))); // R7
  AST_HALF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !(fire && at_end) && !cmd_stop) |=> $stable(half)); // R9
  AST_BLK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !alt_q) |-> (blk <= cfg_last_blk)); // R3
  AST_ITER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !alt_q && cfg_loop_en && !cfg_loop_inf && cfg_loop_cnt != '0) |-> (iter < cfg_loop_cnt)); // R4
endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import seq_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int MEM_BITS = 2048,
  parameter int GRAN     = 512,
  parameter int NBLK     = 4,
  parameter int CNT_W    = 16,
  localparam int BA_W    = $clog2(MEM_BITS),
  localparam int LB_W    = BA_W + 1,
  localparam int WA_W    = BA_W - $clog2(WORD_W),
  localparam int LEN_W   = $clog2(MEM_BITS / GRAN + 1),
  localparam int BLK_W   = $clog2(NBLK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [WA_W-1:0]       wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  cmd_start,
  input  logic                  cmd_stop,
  input  logic                  aux_in,
  input  logic                  cfg_start_aux,
  input  logic                  cfg_alt_en,
  input  logic [1:0]            cfg_aux_mode,
  input  logic                  cfg_oneshot,
  input  logic [BLK_W-1:0]      cfg_last_blk,
  input  logic [NBLK*LEN_W-1:0] cfg_blk_len,
  input  logic                  cfg_loop_en,
  input  logic [BLK_W-1:0]      cfg_loop_first,
  input  logic [BLK_W-1:0]      cfg_loop_last,
  input  logic [CNT_W-1:0]      cfg_loop_cnt,
  input  logic                  cfg_loop_inf,
  input  logic [LEN_W-1:0]      cfg_alt_len,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_bit,
  output logic                  busy,
  output logic                  done,
  output logic [BLK_W-1:0]      cur_blk,
  output logic                  cur_half
);
  logic                 aux_lvl, aux_rise, rd_bit, mute, run;
  logic [BA_W-1:0]      rd_addr;
  logic [NBLK*BA_W-1:0] base_flat;
  logic [NBLK*LB_W-1:0] bits_flat;

  seq_aux_sync u_sync (
    .clk(clk), .rst_n(rst_n), .aux_in(aux_in),
    .aux_lvl(aux_lvl), .aux_rise(aux_rise)
  );

  seq_block_map #(.MEM_BITS(MEM_BITS), .GRAN(GRAN), .NBLK(NBLK)) u_map (
    .cfg_blk_len(cfg_blk_len), .blk_base_flat(base_flat), .blk_bits_flat(bits_flat)
  );

  seq_bit_store #(.WORD_W(WORD_W), .MEM_BITS(MEM_BITS)) u_mem (
    .clk(clk), .wr_en(wr_valid & wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_bit(rd_bit)
  );

  seq_ctrl #(.MEM_BITS(MEM_BITS), .GRAN(GRAN), .NBLK(NBLK), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .aux_lvl(aux_lvl), .aux_rise(aux_rise), .cfg_start_aux(cfg_start_aux),
    .cfg_alt_en(cfg_alt_en), .cfg_aux_mode(cfg_aux_mode), .cfg_oneshot(cfg_oneshot),
    .cfg_last_blk(cfg_last_blk), .cfg_loop_en(cfg_loop_en),
    .cfg_loop_first(cfg_loop_first), .cfg_loop_last(cfg_loop_last),
    .cfg_loop_cnt(cfg_loop_cnt), .cfg_loop_inf(cfg_loop_inf), .cfg_alt_len(cfg_alt_len),
    .blk_base_flat(base_flat), .blk_bits_flat(bits_flat), .out_ready(out_ready),
    .rd_addr(rd_addr), .busy(run), .done(done), .cur_blk(cur_blk), .cur_half(cur_half)
  );

  assign mute      = !cfg_alt_en && (cfg_aux_mode == AUX_MUTE) && aux_lvl;
  assign busy      = run;
  assign out_valid = run;
  assign out_bit   = run & rd_bit & ~mute;
  assign wr_ready  = ~run;

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !out_bit)); // R6
  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_alt_en && cfg_aux_mode == AUX_MUTE && aux_lvl) |-> !out_bit); // R13
endmodule

// File: tb/pseq_top_tb_top.sv
module pseq_top_tb_top;
  localparam int WORD_W = 16, MEM_BITS = 128, GRAN = 8, NBLK = 4, CNT_W = 8;
  localparam int BA_W = $clog2(MEM_BITS), WA_W = BA_W - $clog2(WORD_W);
  localparam int LEN_W = $clog2(MEM_BITS / GRAN + 1), BLK_W = $clog2(NBLK);
  localparam int DEPTH = MEM_BITS / WORD_W, HALF = MEM_BITS / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [WA_W-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, aux_in = 1'b0;
  logic cfg_start_aux = 1'b0, cfg_alt_en = 1'b0, cfg_oneshot = 1'b0;
  logic [1:0] cfg_aux_mode = 2'd0;
  logic [BLK_W-1:0] cfg_last_blk = '0, cfg_loop_first = '0, cfg_loop_last = '0;
  logic [NBLK*LEN_W-1:0] cfg_blk_len = '0;
  logic cfg_loop_en = 1'b0, cfg_loop_inf = 1'b0;
  logic [CNT_W-1:0] cfg_loop_cnt = '0;
  logic [LEN_W-1:0] cfg_alt_len = '0;
  logic out_valid, out_ready = 1'b0, out_bit, busy, done, cur_half;
  logic [BLK_W-1:0] cur_blk;

  pseq_top #(.WORD_W(WORD_W), .MEM_BITS(MEM_BITS), .GRAN(GRAN), .NBLK(NBLK), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .aux_in(aux_in),
    .cfg_start_aux(cfg_start_aux), .cfg_alt_en(cfg_alt_en), .cfg_aux_mode(cfg_aux_mode),
    .cfg_oneshot(cfg_oneshot), .cfg_last_blk(cfg_last_blk), .cfg_blk_len(cfg_blk_len),
    .cfg_loop_en(cfg_loop_en), .cfg_loop_first(cfg_loop_first), .cfg_loop_last(cfg_loop_last),
    .cfg_loop_cnt(cfg_loop_cnt), .cfg_loop_inf(cfg_loop_inf), .cfg_alt_len(cfg_alt_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .busy(busy),
    .done(done), .cur_blk(cur_blk), .cur_half(cur_half)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 1'b0;
  logic [WORD_W-1:0] pat [DEPTH];
  bit exp_q [$];
  string tag_q [$];

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // scoreboard monitor: compares each transferred bit
  always @(negedge clk) begin
    #2;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected bit", int'(out_bit), -1);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(out_bit == e, t, int'(out_bit), int'(e));
      end
    end
  end

  function automatic bit pbit(input int a);
    return pat[a / WORD_W][a % WORD_W];
  endfunction

  task automatic push_bits(input int base, input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back(pbit(base + i));
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_zeros(input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back(1'b0);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    int guard = 0;
    forever begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        out_ready = 1'b0;
        break;
      end
      if (guard > 4000) begin
        out_ready = 1'b0;
        check(1'b0, "R7 drain stalled", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        break;
      end
      out_ready = ((cycles % 7) != 3);
      guard++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) cmd_stop = 1'b1;
    @(negedge clk) cmd_stop = 1'b0;
  endtask

  task automatic set_aux(input bit v);
    @(negedge clk) aux_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_aux();
    @(negedge clk) aux_in = 1'b1;
    repeat (3) @(negedge clk);
    aux_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_word(input int a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = WA_W'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cycles, 0);
    summary();
  end

  initial begin
    for (int w = 0; w < DEPTH; w++) pat[w] = WORD_W'((w * 40503 + 12345) ^ (w << 9));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_bit == 1'b0, "R1 out_bit", int'(out_bit), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    for (int w = 0; w < DEPTH; w++) write_word(w, pat[w]);

    // R3 R4: blocks 1,2,1,1 granules, loop 1..2 played twice
    cfg_blk_len = {5'd1, 5'd1, 5'd2, 5'd1};
    cfg_last_blk = 2'd3; cfg_loop_en = 1'b1; cfg_loop_first = 2'd1; cfg_loop_last = 2'd2;
    cfg_loop_cnt = 8'd2;
    push_bits(0, 8, "R3 blk0");
    push_bits(8, 16, "R3 blk1");
    pulse_start();
    drain();
    check(busy == 1'b1, "R2 busy mid", int'(busy), 1);
    check(wr_ready == 1'b0, "R2 wr_ready while running", int'(wr_ready), 0);
    write_word(0, ~pat[0]);  // R2 must be refused
    pulse_start();           // R8 ignored while running
    push_bits(24, 8, "R3 blk2");
    push_bits(8, 16, "R4 loop blk1");
    push_bits(24, 8, "R4 loop blk2");
    push_bits(32, 8, "R4 blk3 after loop");
    drain();
    @(negedge clk);
    check(done == 1'b1, "R6 done", int'(done), 1);
    check(out_valid == 1'b0, "R6 valid low", int'(out_valid), 0);
    repeat (5) @(negedge clk);
    check(done == 1'b1 && out_bit == 1'b0, "R6 done holds", int'(done), 1);

    // R4 count 0 acts as 1; R2 word 0 unchanged
    cfg_loop_cnt = 8'd0;
    push_bits(0, 8, "R2 word0 intact");
    push_bits(8, 24, "R4 cnt0 blk1-2");
    push_bits(32, 8, "R4 cnt0 blk3");
    pulse_start();
    drain();
    @(negedge clk);
    check(done == 1'b1, "R4 done after single pass", int'(done), 1);

    // R5 infinite loop over 0..1
    cfg_loop_inf = 1'b1; cfg_loop_first = 2'd0; cfg_loop_last = 2'd1;
    for (int k = 0; k < 3; k++) push_bits(0, 24, "R5 loop pass");
    pulse_start();
    drain();
    check(busy == 1'b1, "R5 still running", int'(busy), 1);
    pulse_stop();
    check(busy == 1'b0 && done == 1'b0, "R8 stop to idle", int'(busy), 0);
    cfg_loop_inf = 1'b0; cfg_loop_en = 1'b0;

    // R13 blanking, single block of 2 granules
    cfg_blk_len = {5'd1, 5'd1, 5'd1, 5'd2}; cfg_last_blk = 2'd0; cfg_aux_mode = 2'd3;
    push_bits(0, 4, "R13 before blank");
    pulse_start();
    drain();
    set_aux(1'b1);
    push_zeros(6, "R13 blanked");
    drain();
    set_aux(1'b0);
    push_bits(10, 6, "R13 after blank");
    drain();
    @(negedge clk);
    check(done == 1'b1, "R13 position advanced", int'(done), 1);
    cfg_aux_mode = 2'd0;

    // R8 aux edge ignored without cfg_start_aux, then used as start
    pulse_aux();
    check(busy == 1'b0, "R8 aux no start", int'(busy), 0);
    cfg_start_aux = 1'b1;
    cfg_blk_len = {5'd1, 5'd1, 5'd1, 5'd1};
    push_bits(0, 8, "R8 aux start");
    pulse_aux();
    check(busy == 1'b1, "R8 aux started", int'(busy), 1);
    drain();
    cfg_start_aux = 1'b0;

    // R9 R10 alternate, toggle mode, 16-bit patterns
    cfg_alt_en = 1'b1; cfg_alt_len = 5'd2; cfg_aux_mode = 2'd1; cfg_oneshot = 1'b0;
    push_bits(0, 4, "R9 half0 first");
    pulse_start();
    drain();
    pulse_aux();
    check(cur_half == 1'b0, "R9 no mid-pattern switch", int'(cur_half), 0);
    push_bits(4, 12, "R9 half0 rest");
    push_bits(HALF, 16, "R10 half1");
    push_bits(HALF, 4, "R10 half1 stays");
    drain();
    pulse_aux();
    push_bits(HALF + 4, 12, "R10 half1 rest");
    push_bits(0, 16, "R10 back to half0");
    drain();
    pulse_stop();

    // R11 one-shot
    cfg_oneshot = 1'b1;
    push_bits(0, 4, "R11 half0");
    pulse_start();
    drain();
    pulse_aux();
    push_bits(4, 12, "R11 half0 rest");
    push_bits(HALF, 16, "R11 half1 once");
    push_bits(0, 16, "R11 return half0");
    push_bits(0, 4, "R11 stays half0");
    drain();
    pulse_stop();

    // R12 level select
    cfg_aux_mode = 2'd2; cfg_oneshot = 1'b0;
    push_bits(0, 4, "R12 half0");
    pulse_start();
    drain();
    set_aux(1'b1);
    push_bits(4, 12, "R12 half0 rest");
    push_bits(HALF, 16, "R12 level high");
    push_bits(HALF, 4, "R12 level high again");
    drain();
    set_aux(1'b0);
    push_bits(HALF + 4, 12, "R12 half1 rest");
    push_bits(0, 8, "R12 level low");
    drain();
    pulse_stop();

    // R13 blanking mode has no effect in alternate mode
    cfg_aux_mode = 2'd3;
    set_aux(1'b1);
    push_bits(0, 16, "R13 alt unaffected");
    push_bits(0, 16, "R13 alt half0 repeats");
    pulse_start();
    drain();
    pulse_stop();
    set_aux(1'b0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule